// File: doc/BRIEF.md
# SRAM Power-Cycle Sequencer

This block steps the power and clock control lines of an SRAM array that serves as a start-up entropy source. On a power-on request it walks the array from off to running through a short, fixed series of control words. On a power-cycle request it puts the array to sleep, turns on every power switch to drain the cells, releases the switches in two stages, wakes the array and ends with a low pulse on the init line. After that, the next power-up shows fresh start-up contents.

The discharge hold and the release holds are given as clock-cycle counts on input ports. A surrounding controller picks these counts (a short discharge first, a long one on a retry) and decides when a cycle is needed. Each control word is registered and held for at least one clock, so every intermediate value appears on the output. A one-cycle done pulse marks the end of each sequence.

Top module: `sram_pwr_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `ctrlWord` is 0x00 and `seqDone` is 0.
- R2: The control word encodes RAM-on at bit 0, clock-disable at bit 2, init at bit 3, large power-switch pair at bits 4 and 5, and small power-switch pair at bits 6 and 7. Bit 1 is always 0.
- R3: A power-on request sampled in idle at clock edge k gives 0x05, 0x0D and 0x09, each for one cycle, starting in the cycle after edge k.
- R4: A power-cycle request sampled in idle at edge k gives 0x0D, 0x0C and 0x08, one cycle each, starting in the cycle after edge k. The switch-on word 0xF8 follows.
- R5: 0xF8 is held for D+1 cycles, where D is `dischargeCycles` at entry. A count of 0 still gives one cycle.
- R6: Release is staged. 0x38 is held for U+1 cycles, then 0x08 for U+1 cycles, where U is `usCycles` at entry to each stage.
- R7: Wake-up gives 0x0C, 0x0D and 0x09, then the init-low pulse 0x0D, 0x05 and 0x01, one cycle each.
- R8: `seqDone` is high for exactly one cycle, in the cycle after the last step of a sequence. In idle, `ctrlWord` keeps the last step's value (0x09 after power-on, 0x01 after a power cycle).
- R9: Requests that arrive while a sequence is running are ignored. The running sequence's output stream does not change.
- R10: If both requests are sampled together in idle, the power-cycle sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerOnReq | input | 1 | Request the power-on sequence |
| cycleReq | input | 1 | Request the full power-cycle sequence |
| dischargeCycles | input | DISCH_W | Discharge hold count D |
| usCycles | input | US_W | Release-stage hold count U (about one microsecond) |
| ctrlWord | output | 8 | Registered SRAM power/clock control word |
| seqDone | output | 1 | One-cycle pulse when a sequence ends |

## Verification
A request sampled at edge k moves the first control word onto the output in the cycle right after k. Every later word follows exactly one cycle later, or D+1 or U+1 cycles later for the timed holds. The done pulse comes one cycle after the final word. The bench builds the whole stream of expected words and done values as a per-cycle queue when it drives a request. A monitor samples a quarter period after each rising edge and pops one entry per cycle. Any missing, extra or shifted cycle therefore shows up as a mismatch. Requests injected mid-sequence add nothing to the queue, so any reaction to them is reported.

// File: rtl/sram_pwr_seq_pkg.sv
package sram_pwr_seq_pkg;

  localparam int WORD_W  = 8;
  localparam int BIT_ON  = 0;
  localparam int BIT_CKD = 2;
  localparam int BIT_INI = 3;
  localparam int BIT_LMA = 4;
  localparam int BIT_LMP = 5;
  localparam int BIT_SMA = 6;
  localparam int BIT_SMP = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_CKD, ST_UP_INIT, ST_UP_RUN,
    ST_DN_CKOFF, ST_DN_SLEEP, ST_DN_CKON, ST_DN_DRAIN,
    ST_RL_SMALL, ST_RL_LARGE,
    ST_WK_CKD, ST_WK_ON, ST_WK_RUN,
    ST_PL_CKD, ST_PL_LOW, ST_PL_END
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              ldWord;
    logic [WORD_W-1:0] word;
    logic              ldCnt;
    logic              cntUs;   // 1: load microsecond count, 0: discharge count
    logic              finish;
  } stepStrobe_t;

  function automatic logic [WORD_W-1:0] mkWord(input logic on, input logic ckd,
                                               input logic ini, input logic lg,
                                               input logic sm);
    logic [WORD_W-1:0] w;
    w          = '0;
    w[BIT_ON]  = on;
    w[BIT_CKD] = ckd;
    w[BIT_INI] = ini;
    w[BIT_LMA] = lg;
    w[BIT_LMP] = lg;
    w[BIT_SMA] = sm;
    w[BIT_SMP] = sm;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] wordOf(input seqState_t s);
    case (s)
      ST_UP_CKD:   return mkWord(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      ST_UP_INIT:  return mkWord(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      ST_UP_RUN:   return mkWord(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      ST_DN_CKOFF: return mkWord(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      ST_DN_SLEEP: return mkWord(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      ST_DN_CKON:  return mkWord(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      ST_DN_DRAIN: return mkWord(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      ST_RL_SMALL: return mkWord(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      ST_RL_LARGE: return mkWord(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      ST_WK_CKD:   return mkWord(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      ST_WK_ON:    return mkWord(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      ST_WK_RUN:   return mkWord(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      ST_PL_CKD:   return mkWord(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      ST_PL_LOW:   return mkWord(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      ST_PL_END:   return mkWord(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      default:     return '0;
    endcase
  endfunction

endpackage

// File: rtl/sram_pwr_seq_ctrl.sv
module sram_pwr_seq_ctrl
  import sram_pwr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerOnReq,
  input  logic        cycleReq,
  input  logic        cntZero,
  output stepStrobe_t strobe
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (cycleReq)        stateD = ST_DN_CKOFF;  // power cycle has priority
        else if (powerOnReq) stateD = ST_UP_CKD;
      end
      ST_UP_CKD:   stateD = ST_UP_INIT;
      ST_UP_INIT:  stateD = ST_UP_RUN;
      ST_UP_RUN:   stateD = ST_IDLE;
      ST_DN_CKOFF: stateD = ST_DN_SLEEP;
      ST_DN_SLEEP: stateD = ST_DN_CKON;
      ST_DN_CKON:  stateD = ST_DN_DRAIN;
      ST_DN_DRAIN: if (cntZero) stateD = ST_RL_SMALL;
      ST_RL_SMALL: if (cntZero) stateD = ST_RL_LARGE;
      ST_RL_LARGE: if (cntZero) stateD = ST_WK_CKD;
      ST_WK_CKD:   stateD = ST_WK_ON;
      ST_WK_ON:    stateD = ST_WK_RUN;
      ST_WK_RUN:   stateD = ST_PL_CKD;
      ST_PL_CKD:   stateD = ST_PL_LOW;
      ST_PL_LOW:   stateD = ST_PL_END;
      ST_PL_END:   stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    logic moving;
    moving        = (stateD != stateQ);
    strobe.ldWord = moving && (stateD != ST_IDLE);
    strobe.word   = wordOf(stateD);
    strobe.ldCnt  = moving && ((stateD == ST_DN_DRAIN) || (stateD == ST_RL_SMALL) ||
                               (stateD == ST_RL_LARGE));
    strobe.cntUs  = (stateD != ST_DN_DRAIN);
    strobe.finish = moving && (stateD == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/sram_pwr_seq_dp.sv
module sram_pwr_seq_dp
  import sram_pwr_seq_pkg::*;
#(
  parameter int DISCH_W = 24,
  parameter int US_W    = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  stepStrobe_t        strobe,
  input  logic [DISCH_W-1:0] dischargeCycles,
  input  logic [US_W-1:0]    usCycles,
  output logic               cntZero,
  output logic [WORD_W-1:0]  ctrlWord,
  output logic               seqDone
);

  localparam int CNT_W = (DISCH_W > US_W) ? DISCH_W : US_W;

  logic [CNT_W-1:0]  cntQ;
  logic [WORD_W-1:0] wordQ;
  logic              doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.ldCnt) begin
      cntQ <= strobe.cntUs ? CNT_W'(usCycles) : CNT_W'(dischargeCycles);
    end else if (cntQ != '0) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
      doneQ <= 1'b0;
    end else begin
      if (strobe.ldWord) wordQ <= strobe.word;
      doneQ <= strobe.finish;
    end
  end

  assign cntZero  = (cntQ == '0);
  assign ctrlWord = wordQ;
  assign seqDone  = doneQ;

endmodule

// File: rtl/sram_pwr_seq.sv
module sram_pwr_seq
  import sram_pwr_seq_pkg::*;
#(
  parameter int DISCH_W = 24,
  parameter int US_W    = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               powerOnReq,
  input  logic               cycleReq,
  input  logic [DISCH_W-1:0] dischargeCycles,
  input  logic [US_W-1:0]    usCycles,
  output logic [7:0]         ctrlWord,
  output logic               seqDone
);

  stepStrobe_t strobe;
  logic        cntZero;

  sram_pwr_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerOnReq (powerOnReq),
    .cycleReq   (cycleReq),
    .cntZero    (cntZero),
    .strobe     (strobe)
  );

  sram_pwr_seq_dp #(
    .DISCH_W (DISCH_W),
    .US_W    (US_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .dischargeCycles (dischargeCycles),
    .usCycles        (usCycles),
    .cntZero         (cntZero),
    .ctrlWord        (ctrlWord),
    .seqDone         (seqDone)
  );

endmodule

// File: rtl/sram_pwr_seq_chk.sv
module sram_pwr_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ctrlWord,
  input logic       seqDone
);

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  // R2
  switch_ram_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ctrlWord[7:4]) |-> !ctrlWord[0]);

  // R6
  small_needs_large_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[6] |-> ctrlWord[4]);

  // R4
  drain_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord == 8'hF8 && $past(ctrlWord) != 8'hF8) |-> $past(ctrlWord) == 8'h08);

  // R6
  release_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord == 8'h38 && $past(ctrlWord) != 8'h38) |-> $past(ctrlWord) == 8'hF8);

  // R7
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord == 8'h01 && $past(ctrlWord) != 8'h01) |-> $past(ctrlWord) == 8'h05);

endmodule

bind sram_pwr_seq sram_pwr_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ctrlWord (ctrlWord),
  .seqDone  (seqDone)
);

// File: tb/sram_pwr_seq_tb.sv
module sram_pwr_seq_tb;

  localparam int DISCH_W = 24;
  localparam int US_W    = 10;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               powerOnReq = 1'b0;
  logic               cycleReq = 1'b0;
  logic [DISCH_W-1:0] dischargeCycles = '0;
  logic [US_W-1:0]    usCycles = '0;
  logic [7:0]         ctrlWord;
  logic               seqDone;

  always #10 clk = ~clk;  // 50 MHz

  sram_pwr_seq #(.DISCH_W(DISCH_W), .US_W(US_W)) u_dut (
    .clk(clk), .rstN(rstN), .powerOnReq(powerOnReq), .cycleReq(cycleReq),
    .dischargeCycles(dischargeCycles), .usCycles(usCycles),
    .ctrlWord(ctrlWord), .seqDone(seqDone)
  );

  typedef struct {
    logic [7:0] word;
    logic       done;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit monOn = 1'b0;

  task automatic push(input logic [7:0] w, input logic d, input string tag, input int n);
    for (int i = 0; i < n; i++) expQ.push_back('{w, d, tag});
  endtask

  task automatic expectPowerOn();
    push(8'h05, 1'b0, "R3", 1);
    push(8'h0D, 1'b0, "R3", 1);
    push(8'h09, 1'b0, "R3", 1);
    push(8'h09, 1'b1, "R8", 1);
    push(8'h09, 1'b0, "R8", 2);
  endtask

  task automatic expectCycle(input int d, input int u);
    push(8'h0D, 1'b0, "R4", 1);
    push(8'h0C, 1'b0, "R4", 1);
    push(8'h08, 1'b0, "R4", 1);
    push(8'hF8, 1'b0, "R5", d + 1);
    push(8'h38, 1'b0, "R6", u + 1);
    push(8'h08, 1'b0, "R6", u + 1);
    push(8'h0C, 1'b0, "R7", 1);
    push(8'h0D, 1'b0, "R7", 1);
    push(8'h09, 1'b0, "R7", 1);
    push(8'h0D, 1'b0, "R7", 1);
    push(8'h05, 1'b0, "R7", 1);
    push(8'h01, 1'b0, "R7", 1);
    push(8'h01, 1'b1, "R8", 1);
    push(8'h01, 1'b0, "R8", 2);
  endtask

  // kind: 0 power-on, 1 power cycle, 2 both together (R10); poke: mid-sequence requests (R9)
  task automatic drive(input int kind, input int d, input int u, input bit poke);
    wait (expQ.size() == 0);
    @(negedge clk);
    dischargeCycles = DISCH_W'(d);
    usCycles        = US_W'(u);
    powerOnReq      = (kind != 1);
    cycleReq        = (kind != 0);
    if (kind == 0) expectPowerOn();
    else           expectCycle(d, u);
    @(negedge clk);
    powerOnReq = 1'b0;
    cycleReq   = 1'b0;
    if (poke) begin
      powerOnReq = 1'b1;          // R9: ignored while busy
      @(negedge clk);
      powerOnReq = 1'b0;
      cycleReq   = 1'b1;          // R9: ignored while busy
      @(negedge clk);
      cycleReq   = 1'b0;
    end
    wait (expQ.size() == 0);
  endtask

  // monitor: one entry per cycle, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (monOn && expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        total++;
        if (ctrlWord !== e.word || seqDone !== e.done) begin
          bad++;
          $display("FAIL %s: ctrlWord=%h seqDone=%b expected ctrlWord=%h seqDone=%b",
                   e.tag, ctrlWord, seqDone, e.word, e.done);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;  // R1: during reset
    if (ctrlWord !== 8'h00 || seqDone !== 1'b0) begin
      bad++;
      $display("FAIL R1: ctrlWord=%h seqDone=%b expected ctrlWord=00 seqDone=0", ctrlWord, seqDone);
    end
    rstN = 1'b1;
    @(negedge clk);
    total++;  // R1: first cycle after reset
    if (ctrlWord !== 8'h00 || seqDone !== 1'b0) begin
      bad++;
      $display("FAIL R1: ctrlWord=%h seqDone=%b expected ctrlWord=00 seqDone=0", ctrlWord, seqDone);
    end
    monOn = 1'b1;
    drive(0, 0, 0, 1'b0);   // R3 power-on
    drive(1, 0, 0, 1'b0);   // R5/R6 zero counts give one cycle
    drive(1, 3, 2, 1'b0);   // R4..R7 nominal
    drive(1, 10, 1, 1'b1);  // R9 requests while busy
    drive(0, 0, 0, 1'b1);   // R9 during power-on
    drive(2, 1, 0, 1'b0);   // R10 both requests
    drive(0, 0, 0, 1'b0);   // R2 encoding again after cycle
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: sequence hung, actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule